// File: doc/BRIEF.md
# On-Chip Memory Map Decoder

This block sits beside a 16-bit DSP core and classifies each program or data access, within the same cycle, as a hit on on-chip ROM, a hit on on-chip dual-access RAM, or a transfer that must leave the chip on the external bus. Program addresses are 23 bits wide: the upper seven bits select one of 128 pages of 64K words, and the lower sixteen give the word offset. Data space is a single 64K-word page, so only the lower sixteen address bits count there.

The mapping changes at run time under a three-bit mode register. The first bit removes the on-chip ROM from program space. The second makes the on-chip RAM visible in program page 0 as well as in data space. The third exposes the upper four of the eight RAM blocks in data space. Software writes the register through a one-cycle write strobe and can read it back. While reset is held, the ROM-removal bit follows a strap pin and the other two bits clear. The region selects are combinational from the access inputs and the current register contents, so a register write only affects accesses from the following cycle.

Top module: `memmap_decoder`

## Requirements
- R1: While rst_n is low at a rising clock edge, the mode register loads {2'b00, boot_rom_off}, which is visible on cfg_rdata after the edge; reset overrides any earlier software write.
- R2: When cfg_we is high at a rising edge, cfg_rdata shows cfg_wdata after that edge (bit 0 = ROM removed, bit 1 = RAM overlay into program space, bit 2 = upper RAM blocks in data space); an access presented in the same cycle as the write is decoded with the old mode bits.
- R3: With acc_req low, sel_rom, sel_ram and sel_ext are all 0, whatever the address and space.
- R4: With acc_req high, exactly one of sel_rom, sel_ram, sel_ext is 1.
- R5: A program access (acc_is_data = 0) on page 0 with offset 0xC000 to 0xFFFF selects ROM when mode bit 0 is 0, even when the overlay bit is 1.
- R6: When mode bit 0 is 1, sel_rom never rises; the top 16K of program page 0 then decodes as RAM when the overlay bit is 1, otherwise as external.
- R7: A program access on page 0 outside the active ROM window selects RAM when mode bit 1 is 1 and the external bus when it is 0.
- R8: A program access whose page field acc_addr[22:16] is non-zero always selects the external bus.
- R9: A data access (acc_is_data = 1) with offset 0x0000 to 0x7FFF (RAM blocks 0 to 3) always selects RAM; acc_addr[22:16] is ignored in data space.
- R10: A data access with offset 0x8000 to 0xFFFF (RAM blocks 4 to 7) selects RAM when mode bit 2 is 1 and the external bus when it is 0; ROM is never selected in data space.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_rom_off | input | 1 | Strap pin sampled into mode bit 0 while in reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 3 | Mode register write value |
| cfg_rdata | output | 3 | Current mode register contents |
| acc_req | input | 1 | Access request valid |
| acc_is_data | input | 1 | 1 = data space, 0 = program space |
| acc_addr | input | 23 | Page (upper 7 bits) and word offset (lower 16 bits) |
| sel_rom | output | 1 | Access goes to on-chip ROM |
| sel_ram | output | 1 | Access goes to on-chip RAM |
| sel_ext | output | 1 | Access goes to the external bus |

## Verification
A mode register write and an access decode can fall in the same cycle, and the access must use the bits from before the write. The bench provokes this both in a directed case, removing the ROM while fetching from its window, and in random traffic where writes land on about one cycle in eight alongside live requests. Each decode is judged against a bench model that holds the old mode until the clock edge, and the readback is checked on the cycle after.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

   localparam int MODE_W = 3;

   typedef struct packed {
      logic upper_data;   // bit 2: RAM blocks 4..7 visible in data space
      logic ovly_prog;    // bit 1: RAM also visible in program page 0
      logic rom_off;      // bit 0: on-chip ROM removed from program space
   } mode_t;

   typedef enum logic [1:0] {
      RGN_NONE = 2'd0,
      RGN_ROM  = 2'd1,
      RGN_RAM  = 2'd2,
      RGN_EXT  = 2'd3
   } region_e;

endpackage

// File: rtl/memmap_mode_reg.sv
module memmap_mode_reg
   import memmap_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  strap_rom_off,
   input  logic  wr_en,
   input  mode_t wr_data,
   output mode_t mode_q
);

   mode_t reset_val;

   always_comb begin
      reset_val            = '0;
      reset_val.rom_off    = strap_rom_off;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= reset_val;
      end else if (wr_en) begin
         mode_q <= wr_data;
      end
   end

endmodule

// File: rtl/memmap_region_dec.sv
module memmap_region_dec
   import memmap_pkg::*;
#(
   parameter int OFS_W          = 16,
   parameter int PAGE_W         = 7,
   parameter bit ROM_PRESENT    = 1'b1,
   parameter int ROM_WORDS      = 16384,
   parameter int RAM_WORDS      = 65536,
   parameter int RAM_BLOCKS     = 8,
   parameter int UPPER_BLK_BASE = 4
)(
   input  logic                    req,
   input  logic                    is_data,
   input  logic [PAGE_W+OFS_W-1:0] addr,
   input  mode_t                   mode,
   output region_e                 region
);

   localparam int BLK_WORDS = RAM_WORDS / RAM_BLOCKS;
   localparam int BLK_SH    = $clog2(BLK_WORDS);
   localparam int BLK_IDX_W = $clog2(RAM_BLOCKS);
   localparam int ROM_BASE  = (1 << OFS_W) - ROM_WORDS;

   logic [OFS_W-1:0]     ofs;
   logic [PAGE_W-1:0]    page;
   logic [BLK_IDX_W-1:0] blk;
   logic                 in_ram;
   logic                 in_rom_win;
   logic [RAM_BLOCKS-1:0] data_vis;
   logic                 data_ram_hit;
   logic                 prog_rom_hit;
   logic                 prog_ram_hit;

   assign ofs    = addr[OFS_W-1:0];
   assign page   = addr[PAGE_W+OFS_W-1:OFS_W];
   assign blk    = ofs[BLK_SH +: BLK_IDX_W];
   assign in_ram = ({1'b0, ofs} < RAM_WORDS[OFS_W:0]);

   // visibility of each RAM block in data space
   for (genvar b = 0; b < RAM_BLOCKS; b++) begin : g_blk
      if (b < UPPER_BLK_BASE) begin : g_fixed
         assign data_vis[b] = 1'b1;
      end else begin : g_switched
         assign data_vis[b] = mode.upper_data;
      end
   end

   // ROM window: variant chosen by parameter
   if (ROM_PRESENT) begin : g_rom
      assign in_rom_win = (ofs >= ROM_BASE[OFS_W-1:0]);
   end else begin : g_no_rom
      assign in_rom_win = 1'b0;
   end

   assign data_ram_hit = in_ram && data_vis[blk];
   assign prog_rom_hit = (page == '0) && in_rom_win && !mode.rom_off;
   assign prog_ram_hit = (page == '0) && in_ram && mode.ovly_prog;

   always_comb begin
      if (!req) begin
         region = RGN_NONE;
      end else if (is_data) begin
         region = data_ram_hit ? RGN_RAM : RGN_EXT;
      end else if (prog_rom_hit) begin
         region = RGN_ROM;
      end else if (prog_ram_hit) begin
         region = RGN_RAM;
      end else begin
         region = RGN_EXT;
      end
   end

endmodule

// File: rtl/memmap_sel_drive.sv
module memmap_sel_drive
   import memmap_pkg::*;
(
   input  region_e region,
   output logic    sel_rom,
   output logic    sel_ram,
   output logic    sel_ext
);

   always_comb begin
      sel_rom = 1'b0;
      sel_ram = 1'b0;
      sel_ext = 1'b0;
      unique case (region)
         RGN_ROM:  sel_rom = 1'b1;
         RGN_RAM:  sel_ram = 1'b1;
         RGN_EXT:  sel_ext = 1'b1;
         default:  ;
      endcase
   end

endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
   import memmap_pkg::*;
#(
   parameter int OFS_W          = 16,
   parameter int PAGE_W         = 7,
   parameter bit ROM_PRESENT    = 1'b1,
   parameter int ROM_WORDS      = 16384,
   parameter int RAM_WORDS      = 65536,
   parameter int RAM_BLOCKS     = 8,
   parameter int UPPER_BLK_BASE = 4
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    boot_rom_off,
   input  logic                    cfg_we,
   input  logic [MODE_W-1:0]       cfg_wdata,
   output logic [MODE_W-1:0]       cfg_rdata,
   input  logic                    acc_req,
   input  logic                    acc_is_data,
   input  logic [PAGE_W+OFS_W-1:0] acc_addr,
   output logic                    sel_rom,
   output logic                    sel_ram,
   output logic                    sel_ext
);

   // elaboration-time parameter checks
   if (RAM_BLOCKS < 2 || (RAM_BLOCKS & (RAM_BLOCKS - 1)) != 0) begin : g_bad_blocks
      $error("RAM_BLOCKS must be a power of two, at least 2");
   end
   if (RAM_WORDS > (1 << OFS_W) || (RAM_WORDS % RAM_BLOCKS) != 0) begin : g_bad_ram
      $error("RAM_WORDS must fit the offset and divide into blocks");
   end
   if (ROM_WORDS < 1 || ROM_WORDS >= (1 << OFS_W)) begin : g_bad_rom
      $error("ROM_WORDS must be between 1 and one page minus one");
   end
   if (UPPER_BLK_BASE < 0 || UPPER_BLK_BASE > RAM_BLOCKS) begin : g_bad_split
      $error("UPPER_BLK_BASE out of range");
   end

   mode_t   mode_q;
   region_e region;

   memmap_mode_reg u_mode (
      .clk           (clk),
      .rst_n         (rst_n),
      .strap_rom_off (boot_rom_off),
      .wr_en         (cfg_we),
      .wr_data       (mode_t'(cfg_wdata)),
      .mode_q        (mode_q)
   );

   memmap_region_dec #(
      .OFS_W          (OFS_W),
      .PAGE_W         (PAGE_W),
      .ROM_PRESENT    (ROM_PRESENT),
      .ROM_WORDS      (ROM_WORDS),
      .RAM_WORDS      (RAM_WORDS),
      .RAM_BLOCKS     (RAM_BLOCKS),
      .UPPER_BLK_BASE (UPPER_BLK_BASE)
   ) u_dec (
      .req     (acc_req),
      .is_data (acc_is_data),
      .addr    (acc_addr),
      .mode    (mode_q),
      .region  (region)
   );

   memmap_sel_drive u_sel (
      .region  (region),
      .sel_rom (sel_rom),
      .sel_ram (sel_ram),
      .sel_ext (sel_ext)
   );

   assign cfg_rdata = mode_q;

endmodule

// File: rtl/memmap_decoder_chk.sv
module memmap_decoder_chk #(
   parameter int OFS_W  = 16,
   parameter int PAGE_W = 7
)(
   input logic                    clk,
   input logic                    rst_n,
   input logic                    cfg_we,
   input logic [2:0]              cfg_wdata,
   input logic [2:0]              cfg_rdata,
   input logic                    acc_req,
   input logic                    acc_is_data,
   input logic [PAGE_W+OFS_W-1:0] acc_addr,
   input logic                    sel_rom,
   input logic                    sel_ram,
   input logic                    sel_ext
);

   a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_req |-> !(sel_rom || sel_ram || sel_ext));

   a_r4_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      acc_req |-> $countones({sel_rom, sel_ram, sel_ext}) == 1);

   a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> cfg_rdata == $past(cfg_wdata));

   a_r6_rom_removed: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[0] |-> !sel_rom);

   a_r8_far_page_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req && !acc_is_data && acc_addr[PAGE_W+OFS_W-1:OFS_W] != '0) |-> sel_ext);

   a_r10_no_data_rom: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req && acc_is_data) |-> !sel_rom);

endmodule

bind memmap_decoder memmap_decoder_chk #(.OFS_W(OFS_W), .PAGE_W(PAGE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_we      (cfg_we),
   .cfg_wdata   (cfg_wdata),
   .cfg_rdata   (cfg_rdata),
   .acc_req     (acc_req),
   .acc_is_data (acc_is_data),
   .acc_addr    (acc_addr),
   .sel_rom     (sel_rom),
   .sel_ram     (sel_ram),
   .sel_ext     (sel_ext)
);

// File: tb/memmap_decoder_tb.sv
module memmap_decoder_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        boot_rom_off = 1'b1;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_wdata = '0;
   logic [2:0]  cfg_rdata;
   logic        acc_req = 1'b0;
   logic        acc_is_data = 1'b0;
   logic [22:0] acc_addr = '0;
   logic        sel_rom, sel_ram, sel_ext;

   int total = 0;
   int bad   = 0;
   logic [2:0] mmode = '0;   // bench model of the mode bits
   bit done = 0;

   always #5 clk = ~clk;

   memmap_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .boot_rom_off(boot_rom_off),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .acc_req(acc_req), .acc_is_data(acc_is_data), .acc_addr(acc_addr),
      .sel_rom(sel_rom), .sel_ram(sel_ram), .sel_ext(sel_ext)
   );

   // expected {ext, ram, rom}
   function automatic logic [2:0] model(input logic [2:0] m, input logic rq,
                                        input logic sp, input logic [22:0] a);
      logic [15:0] ofs = a[15:0];
      if (!rq) return 3'b000;
      if (sp) begin
         if (ofs < 16'h8000) return 3'b010;
         return m[2] ? 3'b010 : 3'b100;
      end
      if (a[22:16] != 7'd0) return 3'b100;
      if (!m[0] && ofs >= 16'hC000) return 3'b001;
      return m[1] ? 3'b010 : 3'b100;
   endfunction

   function automatic string tag_of(input logic [2:0] m, input logic rq,
                                    input logic sp, input logic [22:0] a);
      if (!rq) return "R3";
      if (sp) return a[15] ? "R10" : "R9";
      if (a[22:16] != 7'd0) return "R8";
      if (a[15:14] == 2'b11) return m[0] ? "R6" : "R5";
      return "R7";
   endfunction

   task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // one cycle: drive at negedge, check decode, then let the edge land
   task automatic step(input logic rq, input logic sp, input logic [22:0] a,
                       input logic we, input logic [2:0] wd, input string tag);
      logic [2:0] sels;
      @(negedge clk);
      acc_req = rq; acc_is_data = sp; acc_addr = a; cfg_we = we; cfg_wdata = wd;
      #2;
      sels = {sel_ext, sel_ram, sel_rom};
      chk(tag, sels, model(mmode, rq, sp, a));
      if (rq) chk("R4", 3'($countones(sels)), 3'd1);
      chk("R2", cfg_rdata, mmode);
      @(posedge clk);
      if (we) mmode = wd;
   endtask

   task automatic do_reset(input logic pin);
      @(negedge clk);
      rst_n = 1'b0; boot_rom_off = pin; cfg_we = 1'b0; acc_req = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      mmode = {2'b00, pin};
      #2;
      chk("R1", cfg_rdata, {2'b00, pin});
      @(posedge clk);
   endtask

   initial begin
      int unused;
      unused = $urandom(32'h5eed);

      // R1: strap high
      do_reset(1'b1);
      // R6: ROM removed, no overlay -> top window external
      step(1, 0, 23'h00C000, 0, 3'b000, "R6");
      step(1, 0, 23'h00FFFF, 0, 3'b000, "R6");
      // R3: idle with interesting address
      step(0, 0, 23'h00C000, 0, 3'b000, "R3");
      step(0, 1, 23'h000000, 0, 3'b000, "R3");

      // write ROM on, overlay on; R2 same-cycle access sees old bits
      step(1, 0, 23'h00C000, 1, 3'b010, "R2");
      step(1, 0, 23'h00C000, 0, 3'b000, "R5");
      step(1, 0, 23'h00BFFF, 0, 3'b000, "R7");
      step(1, 0, 23'h000000, 0, 3'b000, "R7");
      step(1, 0, 23'h010000, 0, 3'b000, "R8");
      step(1, 0, 23'h7FC000, 0, 3'b000, "R8");

      // remove ROM while fetching from its window (R2 same cycle)
      step(1, 0, 23'h00FFFF, 1, 3'b011, "R2");
      step(1, 0, 23'h00FFFF, 0, 3'b000, "R6");

      // data space: upper blocks off then on
      step(1, 1, 23'h7F7FFF, 1, 3'b000, "R9");
      step(1, 1, 23'h008000, 0, 3'b000, "R10");
      step(1, 1, 23'h00C000, 0, 3'b000, "R10");
      step(1, 0, 23'h000100, 0, 3'b000, "R7");
      step(1, 1, 23'h008000, 1, 3'b100, "R10");
      step(1, 1, 23'h008000, 0, 3'b000, "R10");
      step(1, 1, 23'h01FFFF, 0, 3'b000, "R9");

      // R1: reset overrides a written value, strap low
      do_reset(1'b0);
      step(1, 0, 23'h00C000, 0, 3'b000, "R5");

      // random traffic
      for (int i = 0; i < 600; i++) begin
         logic        rq = ($urandom % 8) != 0;
         logic        sp = $urandom % 2;
         logic [22:0] a;
         logic        we = ($urandom % 8) == 0;
         logic [2:0]  wd = 3'($urandom);
         case ($urandom % 4)
            0: a = {7'd0, 16'($urandom)};
            1: a = {7'd0, 2'b11, 14'($urandom)};
            2: a = 23'($urandom);
            default: a = {7'd0, 1'b1, 15'($urandom)};
         endcase
         step(rq, sp, a, we, wd, tag_of(mmode, rq, sp, a));
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule